// File: doc/BRIEF.md
# Micro-TLB Pair with Selective Invalidation

This block holds two small, fully associative translation caches built from flops. They sit in front of a larger set-associative joint TLB. The data side has eight entries and the instruction side has four. Each side answers a lookup (virtual page number plus address-space identifier) in the same cycle. It returns a hit flag, the physical frame number and a six-bit permission vector.

When a lookup misses, the side raises a miss request. The requester keeps the lookup steady until the joint TLB returns a fill. The fill is written into the next entry chosen by a round-robin pointer, unless an entry with the same key is already present, in which case that entry is rewritten in place.

The joint TLB may later replace its own copy of a translation. That has no effect here: an entry leaves the micro-TLB only when its own round-robin pointer reuses the slot, or when the shared flush pulse clears both sides at once. Because each side has more ways than a joint-TLB set, pages that collide in one joint-TLB set can all stay resident together.

Top module: `mtlb_pair`

## Requirements
- R1: After reset no entry is valid: a lookup on either side gives hit=0 and miss=1, and with the request low both hit and miss are 0.
- R2: A lookup hits in the same cycle when an entry has the same virtual page number and the same ASID. It then returns that entry's frame number. A lookup with the same page number and a different ASID misses.
- R3: An entry filled with the global flag set matches its page number under any ASID.
- R4: Fill permissions arrive as three bits rwx (bit 2 read, bit 1 write, bit 0 execute). The returned six-bit vector holds the kernel triad in bits 5:3 and the user triad in bits 2:0, each ordered read, write, execute from MSB. A global fill returns {rwx,000}. A non-global fill returns {rwx,rwx}.
- R5: A missing lookup holds miss high for as long as the request is held. A fill presented on a clock edge makes the same key hit on the very next lookup cycle.
- R6: Fills of new keys go to slots in round-robin order. On an N-entry side, the (N+1)th new key replaces the first one filled since the last flush and leaves the second one in place.
- R7: A fill whose key already hits is written over that entry: the new frame and permissions are returned, no second copy appears, and the round-robin pointer does not move.
- R8: One flush pulse invalidates every entry of both sides on one clock edge. Lookups after that edge miss.
- R9: A flush and a fill on the same edge leave the filled key absent, because the flush wins.
- R10: Each side keeps its entries regardless of what happens to the joint TLB. Three pages that share low address bits stay resident together on each side, and a fill on one side is never visible on the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Invalidate all entries of both sides |
| d_req | input | 1 | Data-side lookup valid |
| d_vpn | input | VPN_W | Data-side lookup page number |
| d_asid | input | ASID_W | Data-side lookup ASID |
| d_hit | output | 1 | Data-side hit |
| d_miss | output | 1 | Data-side miss request to joint TLB |
| d_pfn | output | PFN_W | Data-side frame number |
| d_perm | output | 6 | Data-side permissions {Kr,Kw,Kx,Ur,Uw,Ux} |
| d_fill | input | 1 | Data-side fill valid |
| d_fill_vpn | input | VPN_W | Fill page number |
| d_fill_asid | input | ASID_W | Fill ASID |
| d_fill_glob | input | 1 | Fill is global |
| d_fill_pfn | input | PFN_W | Fill frame number |
| d_fill_rwx | input | 3 | Fill rwx bits |
| i_req | input | 1 | Instruction-side lookup valid |
| i_vpn | input | VPN_W | Instruction-side lookup page number |
| i_asid | input | ASID_W | Instruction-side lookup ASID |
| i_hit | output | 1 | Instruction-side hit |
| i_miss | output | 1 | Instruction-side miss request |
| i_pfn | output | PFN_W | Instruction-side frame number |
| i_perm | output | 6 | Instruction-side permissions |
| i_fill | input | 1 | Instruction-side fill valid |
| i_fill_vpn | input | VPN_W | Fill page number |
| i_fill_asid | input | ASID_W | Fill ASID |
| i_fill_glob | input | 1 | Fill is global |
| i_fill_pfn | input | PFN_W | Fill frame number |
| i_fill_rwx | input | 3 | Fill rwx bits |

## Verification
Hit, miss, frame and permissions are combinational from the entry flops, so they are due in the same cycle as the lookup. A fill or flush takes effect on the rising edge that samples it and is visible on the first lookup after that edge. The bench changes inputs just after a falling edge and reads the outputs 1 ns later, before the next rising edge. Each fill or flush is held across exactly one rising edge, and the lookup that checks it is presented after the following falling edge.

// File: rtl/mtlb_pkg.sv
`timescale 1ns/1ps
package mtlb_pkg;
   localparam int RWX_W  = 3;
   localparam int PERM_W = 2 * RWX_W;

   // kernel triad in the upper half, user triad in the lower half
   function automatic logic [PERM_W-1:0] widen_perm(input logic [RWX_W-1:0] rwx,
                                                    input logic glob);
      widen_perm = glob ? {rwx, {RWX_W{1'b0}}} : {rwx, rwx};
   endfunction
endpackage

// File: rtl/mtlb_match.sv
`timescale 1ns/1ps
module mtlb_match #(
   parameter int N      = 8,
   parameter int VPN_W  = 19,
   parameter int ASID_W = 8
) (
   input  logic [N-1:0]             ent_valid,
   input  logic [N-1:0]             ent_glob,
   input  logic [N-1:0][VPN_W-1:0]  ent_vpn,
   input  logic [N-1:0][ASID_W-1:0] ent_asid,
   input  logic [VPN_W-1:0]         key_vpn,
   input  logic [ASID_W-1:0]        key_asid,
   output logic [N-1:0]             hits
);
   for (genvar g = 0; g < N; g++) begin : g_cmp
      assign hits[g] = ent_valid[g] && (ent_vpn[g] == key_vpn) &&
                       (ent_glob[g] || (ent_asid[g] == key_asid));
   end
endmodule

// File: rtl/mtlb_victim.sv
`timescale 1ns/1ps
module mtlb_victim #(
   parameter  int N     = 8,
   localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             advance,
   output logic [IDX_W-1:0] ptr
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

   initial begin : param_chk
      if (N < 2) $fatal(1, "mtlb_victim: N must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ptr <= '0;
      else if (clear)   ptr <= '0;
      else if (advance) ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
   end

   // R6
   advance_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && !clear) |=> (ptr != $past(ptr)));
endmodule

// File: rtl/mtlb_core.sv
`timescale 1ns/1ps
module mtlb_core #(
   parameter int N      = 8,
   parameter int VPN_W  = 19,
   parameter int PFN_W  = 19,
   parameter int ASID_W = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       flush,
   input  logic                       req,
   input  logic [VPN_W-1:0]           vpn,
   input  logic [ASID_W-1:0]          asid,
   output logic                       hit,
   output logic                       miss,
   output logic [PFN_W-1:0]           pfn,
   output logic [mtlb_pkg::PERM_W-1:0] perm,
   input  logic                       fill,
   input  logic [VPN_W-1:0]           fill_vpn,
   input  logic [ASID_W-1:0]          fill_asid,
   input  logic                       fill_glob,
   input  logic [PFN_W-1:0]           fill_pfn,
   input  logic [mtlb_pkg::RWX_W-1:0] fill_rwx
);
   localparam int IDX_W  = (N > 1) ? $clog2(N) : 1;
   localparam int PERM_W = mtlb_pkg::PERM_W;

   initial begin : param_chk
      if (N < 2)     $fatal(1, "mtlb_core: N must be at least 2");
      if (VPN_W < 1) $fatal(1, "mtlb_core: VPN_W must be positive");
      if (PFN_W < 1) $fatal(1, "mtlb_core: PFN_W must be positive");
   end

   logic [N-1:0]             valid_q, glob_q;
   logic [N-1:0][VPN_W-1:0]  vpn_q;
   logic [N-1:0][ASID_W-1:0] asid_q;
   logic [N-1:0][PFN_W-1:0]  pfn_q;
   logic [N-1:0][PERM_W-1:0] perm_q;

   logic [N-1:0]     lk_hits, fill_hits, slot_sel, wr_sel;
   logic [IDX_W-1:0] ptr;
   logic             install, in_place;

   mtlb_match #(.N(N), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_lk_match (
      .ent_valid(valid_q), .ent_glob(glob_q), .ent_vpn(vpn_q), .ent_asid(asid_q),
      .key_vpn(vpn), .key_asid(asid), .hits(lk_hits));

   mtlb_match #(.N(N), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_fill_match (
      .ent_valid(valid_q), .ent_glob(glob_q), .ent_vpn(vpn_q), .ent_asid(asid_q),
      .key_vpn(fill_vpn), .key_asid(fill_asid), .hits(fill_hits));

   assign install  = fill && !flush;
   assign in_place = |fill_hits;

   mtlb_victim #(.N(N)) u_victim (
      .clk(clk), .rst_n(rst_n), .clear(flush),
      .advance(install && !in_place), .ptr(ptr));

   always_comb begin
      for (int i = 0; i < N; i++) slot_sel[i] = (ptr == IDX_W'(i));
   end
   assign wr_sel = in_place ? fill_hits : slot_sel;

   assign hit  = req && (|lk_hits);
   assign miss = req && !(|lk_hits);

   always_comb begin
      pfn  = '0;
      perm = '0;
      for (int i = 0; i < N; i++) begin
         if (req && lk_hits[i]) begin
            pfn  = pfn  | pfn_q[i];
            perm = perm | perm_q[i];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= '0;
         glob_q  <= '0;
         vpn_q   <= '0;
         asid_q  <= '0;
         pfn_q   <= '0;
         perm_q  <= '0;
      end else if (flush) begin
         valid_q <= '0;
      end else if (install) begin
         for (int i = 0; i < N; i++) begin
            if (wr_sel[i]) begin
               valid_q[i] <= 1'b1;
               glob_q[i]  <= fill_glob;
               vpn_q[i]   <= fill_vpn;
               asid_q[i]  <= fill_asid;
               pfn_q[i]   <= fill_pfn;
               perm_q[i]  <= mtlb_pkg::widen_perm(fill_rwx, fill_glob);
            end
         end
      end
   end

   // R2
   single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lk_hits));
   // R4
   perm_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && (perm[2:0] != 3'b000)) |-> (perm[2:0] == perm[5:3]));
   // R6
   no_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !flush |=> ($countones(valid_q) >= $countones($past(valid_q))));
   // R8
   flush_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !hit);
   // R9
   flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> ($countones(valid_q) == 0));
endmodule

// File: rtl/mtlb_pair.sv
`timescale 1ns/1ps
module mtlb_pair #(
   parameter int D_ENTRIES = 8,
   parameter int I_ENTRIES = 4,
   parameter int VPN_W     = 19,
   parameter int PFN_W     = 19,
   parameter int ASID_W    = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              d_req,
   input  logic [VPN_W-1:0]  d_vpn,
   input  logic [ASID_W-1:0] d_asid,
   output logic              d_hit,
   output logic              d_miss,
   output logic [PFN_W-1:0]  d_pfn,
   output logic [5:0]        d_perm,
   input  logic              d_fill,
   input  logic [VPN_W-1:0]  d_fill_vpn,
   input  logic [ASID_W-1:0] d_fill_asid,
   input  logic              d_fill_glob,
   input  logic [PFN_W-1:0]  d_fill_pfn,
   input  logic [2:0]        d_fill_rwx,
   input  logic              i_req,
   input  logic [VPN_W-1:0]  i_vpn,
   input  logic [ASID_W-1:0] i_asid,
   output logic              i_hit,
   output logic              i_miss,
   output logic [PFN_W-1:0]  i_pfn,
   output logic [5:0]        i_perm,
   input  logic              i_fill,
   input  logic [VPN_W-1:0]  i_fill_vpn,
   input  logic [ASID_W-1:0] i_fill_asid,
   input  logic              i_fill_glob,
   input  logic [PFN_W-1:0]  i_fill_pfn,
   input  logic [2:0]        i_fill_rwx
);
   initial begin : param_chk
      if (mtlb_pkg::PERM_W != 6) $fatal(1, "mtlb_pair: permission width must be 6");
   end

   mtlb_core #(.N(D_ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W), .ASID_W(ASID_W)) u_dtlb (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .req(d_req), .vpn(d_vpn), .asid(d_asid),
      .hit(d_hit), .miss(d_miss), .pfn(d_pfn), .perm(d_perm),
      .fill(d_fill), .fill_vpn(d_fill_vpn), .fill_asid(d_fill_asid),
      .fill_glob(d_fill_glob), .fill_pfn(d_fill_pfn), .fill_rwx(d_fill_rwx));

   mtlb_core #(.N(I_ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W), .ASID_W(ASID_W)) u_itlb (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .req(i_req), .vpn(i_vpn), .asid(i_asid),
      .hit(i_hit), .miss(i_miss), .pfn(i_pfn), .perm(i_perm),
      .fill(i_fill), .fill_vpn(i_fill_vpn), .fill_asid(i_fill_asid),
      .fill_glob(i_fill_glob), .fill_pfn(i_fill_pfn), .fill_rwx(i_fill_rwx));
endmodule

// File: tb/sim_mtlb_pair.sv
`timescale 1ns/1ps
module sim_mtlb_pair;
   localparam int VW = 19, PW = 19, AW = 8;
   localparam int DN = 8, IN = 4;

   logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0;
   logic d_req = 0, d_fill = 0, d_fill_glob = 0, d_hit, d_miss;
   logic i_req = 0, i_fill = 0, i_fill_glob = 0, i_hit, i_miss;
   logic [VW-1:0] d_vpn = '0, d_fill_vpn = '0, i_vpn = '0, i_fill_vpn = '0;
   logic [AW-1:0] d_asid = '0, d_fill_asid = '0, i_asid = '0, i_fill_asid = '0;
   logic [PW-1:0] d_pfn, i_pfn, d_fill_pfn = '0, i_fill_pfn = '0;
   logic [5:0]    d_perm, i_perm;
   logic [2:0]    d_fill_rwx = '0, i_fill_rwx = '0;

   int nchk = 0, nerr = 0;

   always #2.5 clk = ~clk;

   mtlb_pair u0 (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .d_req(d_req), .d_vpn(d_vpn), .d_asid(d_asid), .d_hit(d_hit), .d_miss(d_miss),
      .d_pfn(d_pfn), .d_perm(d_perm), .d_fill(d_fill), .d_fill_vpn(d_fill_vpn),
      .d_fill_asid(d_fill_asid), .d_fill_glob(d_fill_glob), .d_fill_pfn(d_fill_pfn),
      .d_fill_rwx(d_fill_rwx),
      .i_req(i_req), .i_vpn(i_vpn), .i_asid(i_asid), .i_hit(i_hit), .i_miss(i_miss),
      .i_pfn(i_pfn), .i_perm(i_perm), .i_fill(i_fill), .i_fill_vpn(i_fill_vpn),
      .i_fill_asid(i_fill_asid), .i_fill_glob(i_fill_glob), .i_fill_pfn(i_fill_pfn),
      .i_fill_rwx(i_fill_rwx));

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // present a lookup after a falling edge and check it 1 ns later
   task automatic probe(input int side, input logic [VW-1:0] vpn, input logic [AW-1:0] asid,
                        input logic exp_hit, input logic [PW-1:0] exp_pfn,
                        input logic [5:0] exp_perm, input string tag);
      logic h, m;
      logic [PW-1:0] f;
      logic [5:0] p;
      @(negedge clk);
      if (side == 0) begin d_req = 1; d_vpn = vpn; d_asid = asid; i_req = 0; end
      else           begin i_req = 1; i_vpn = vpn; i_asid = asid; d_req = 0; end
      #1;
      h = side ? i_hit : d_hit;   m = side ? i_miss : d_miss;
      f = side ? i_pfn : d_pfn;   p = side ? i_perm : d_perm;
      check({tag, " hit"}, 32'(h), 32'(exp_hit));
      check({tag, " miss"}, 32'(m), 32'(!exp_hit));
      if (exp_hit) begin
         check({tag, " pfn"}, 32'(f), 32'(exp_pfn));
         check({tag, " perm"}, 32'(p), 32'(exp_perm));
      end
   endtask

   task automatic do_fill(input int side, input logic [VW-1:0] vpn, input logic [AW-1:0] asid,
                          input logic glob, input logic [PW-1:0] pfn, input logic [2:0] rwx,
                          input logic with_flush);
      @(negedge clk);
      flush = with_flush;
      if (side == 0) begin
         d_fill = 1; d_fill_vpn = vpn; d_fill_asid = asid; d_fill_glob = glob;
         d_fill_pfn = pfn; d_fill_rwx = rwx;
      end else begin
         i_fill = 1; i_fill_vpn = vpn; i_fill_asid = asid; i_fill_glob = glob;
         i_fill_pfn = pfn; i_fill_rwx = rwx;
      end
      @(negedge clk);
      d_fill = 0; i_fill = 0; flush = 0;
   endtask

   task automatic pulse_flush();
      @(negedge clk); flush = 1;
      @(negedge clk); flush = 0;
   endtask

   task automatic t_reset();
      #1;
      check("R1 idle d_hit", 32'(d_hit), 0);
      check("R1 idle d_miss", 32'(d_miss), 0);
      check("R1 idle i_miss", 32'(i_miss), 0);
      probe(0, 19'h00123, 8'h01, 0, '0, '0, "R1 d empty");
      probe(1, 19'h00123, 8'h01, 0, '0, '0, "R1 i empty");
      // R5: miss stays high while the lookup is held
      @(negedge clk); #1;
      check("R5 miss held", 32'(i_miss), 1);
   endtask

   task automatic t_basic();
      pulse_flush();
      probe(0, 19'h00100, 8'h05, 0, '0, '0, "R5 before fill");
      do_fill(0, 19'h00100, 8'h05, 0, 19'h1ABCD, 3'b111, 0);
      probe(0, 19'h00100, 8'h05, 1, 19'h1ABCD, 6'h3F, "R5 after fill");
      probe(0, 19'h00100, 8'h06, 0, '0, '0, "R2 other asid");
      probe(0, 19'h00101, 8'h05, 0, '0, '0, "R2 other vpn");
   endtask

   task automatic t_global_perm();
      pulse_flush();
      do_fill(0, 19'h00400, 8'h01, 1, 19'h00444, 3'b101, 0);
      probe(0, 19'h00400, 8'h77, 1, 19'h00444, 6'b101000, "R3 R4 global any asid");
      do_fill(0, 19'h00401, 8'h01, 0, 19'h00555, 3'b110, 0);
      probe(0, 19'h00401, 8'h02, 0, '0, '0, "R3 nonglobal other asid");
      probe(0, 19'h00401, 8'h01, 1, 19'h00555, 6'b110110, "R4 nonglobal mirrored");
   endtask

   task automatic t_round_robin(input int side, input int n);
      pulse_flush();
      for (int k = 0; k < n; k++)
         do_fill(side, 19'h00200 + 19'(k), 8'h05, 0, 19'h00300 + 19'(k), 3'b111, 0);
      for (int k = 0; k < n; k++)
         probe(side, 19'h00200 + 19'(k), 8'h05, 1, 19'h00300 + 19'(k), 6'h3F, "R6 full set");
      do_fill(side, 19'h00200 + 19'(n), 8'h05, 0, 19'h00300 + 19'(n), 3'b111, 0);
      probe(side, 19'h00200, 8'h05, 0, '0, '0, "R6 oldest evicted");
      probe(side, 19'h00201, 8'h05, 1, 19'h00301, 6'h3F, "R6 second kept");
      probe(side, 19'h00200 + 19'(n), 8'h05, 1, 19'h00300 + 19'(n), 6'h3F, "R6 newest");
   endtask

   task automatic t_rewrite();
      pulse_flush();
      do_fill(0, 19'h00600, 8'h03, 0, 19'h000F0, 3'b111, 0);
      do_fill(0, 19'h00600, 8'h03, 0, 19'h0000F, 3'b100, 0);
      probe(0, 19'h00600, 8'h03, 1, 19'h0000F, 6'b100100, "R7 rewritten");
      for (int k = 1; k < DN; k++)
         do_fill(0, 19'h00600 + 19'(k), 8'h03, 0, 19'h00700 + 19'(k), 3'b001, 0);
      probe(0, 19'h00600, 8'h03, 1, 19'h0000F, 6'b100100, "R7 pointer held");
      probe(0, 19'h00601, 8'h03, 1, 19'h00701, 6'b001001, "R7 first other");
   endtask

   task automatic t_flush();
      probe(0, 19'h00601, 8'h03, 1, 19'h00701, 6'b001001, "R8 before flush");
      do_fill(1, 19'h00800, 8'h03, 0, 19'h00888, 3'b010, 0);
      pulse_flush();
      probe(0, 19'h00601, 8'h03, 0, '0, '0, "R8 d cleared");
      probe(0, 19'h00600, 8'h03, 0, '0, '0, "R8 d cleared 2");
      probe(1, 19'h00800, 8'h03, 0, '0, '0, "R8 i cleared");
   endtask

   task automatic t_flush_fill();
      do_fill(0, 19'h00500, 8'h09, 0, 19'h00999, 3'b011, 1);
      probe(0, 19'h00500, 8'h09, 0, '0, '0, "R9 flush wins");
      do_fill(0, 19'h00500, 8'h09, 0, 19'h00999, 3'b011, 0);
      probe(0, 19'h00500, 8'h09, 1, 19'h00999, 6'b011011, "R9 later fill");
   endtask

   task automatic t_same_set();
      pulse_flush();
      for (int s = 0; s < 2; s++)
         for (int k = 0; k < 3; k++)
            do_fill(s, 19'h00040 | (19'(k) << 16), 8'h02, 0, 19'h00A00 + 19'(k), 3'b110, 0);
      for (int s = 0; s < 2; s++)
         for (int k = 0; k < 3; k++)
            probe(s, 19'h00040 | (19'(k) << 16), 8'h02, 1, 19'h00A00 + 19'(k), 6'b110110,
                  "R10 colliding pages resident");
      do_fill(0, 19'h30040, 8'h02, 0, 19'h00A03, 3'b110, 0);
      probe(1, 19'h30040, 8'h02, 0, '0, '0, "R10 sides independent");
   endtask

   initial begin : watchdog
      #(200000 * 5);
      nerr++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      t_reset();
      @(negedge clk); rst_n = 1; d_req = 0; i_req = 0;
      t_reset();
      t_basic();
      t_global_perm();
      t_round_robin(0, DN);
      t_round_robin(1, IN);
      t_rewrite();
      t_flush();
      t_flush_fill();
      t_same_set();
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end
endmodule